// File: doc/BRIEF.md
# Fast-Lock Charge-Pump Interval Timer

This block governs the fast-lock phase of a fractional-N PLL. When a lock-acceleration interval is requested, it closes a loop-filter bypass switch and hands the loop to the high-current charge pump. The interval lasts a programmable number of phase-detector periods. When the interval ends, it opens the switch and gives control back to the normal charge pump. The phase-detector period reaches the block as a single-cycle tick on the system clock.

An interval has two possible causes. One is a frequency-change pulse raised by the register logic. The other is a low-to-high transition of the PLL power-down pin, which returns the loop to operation. Both are honoured only while the fast-lock enable bit is set and the programmed count is non-zero. Driving the power-down pin low aborts any interval at once.

Top module: `fastlock_timer`

## Requirements
- R1: After reset, `busy`, `switch_on` and `cp2_sel` are 0 and `cp1_sel` is 1. Whenever `busy` is 0, the outputs are in this idle pattern.
- R2: A start happens when `freq_chg` is 1 while `fast_en` is 1, `pll_run` is 1 and `fast_count` is non-zero. From the next clock edge, `busy`, `switch_on` and `cp2_sel` are 1 and `cp1_sel` is 0.
- R3: A start also happens when `pll_run` is sampled 1 on an edge after being sampled 0 on the previous edge, under the same conditions on `fast_en` and `fast_count`. Holding `pll_run` at 1 does not start another interval. The sampled level is 0 after reset.
- R4: An interval started with count N stays active through N-1 cycles that have `pfd_tick` at 1. It ends on the clock edge that samples the N-th `pfd_tick`, after which the outputs are idle. Cycles without a tick do not shorten it.
- R5: While `fast_en` is 0, neither `freq_chg` nor a rising `pll_run` starts an interval, and `cp1_sel` stays 1.
- R6: A trigger that arrives while `fast_count` is 0 starts nothing.
- R7: A start during an active interval reloads the current `fast_count`. The interval then ends after that many further ticks.
- R8: While `pll_run` is 0, the timer is cleared on each edge and no trigger is accepted. The outputs are idle from the next edge.
- R9: When a start and a `pfd_tick` arrive in the same cycle, the start wins and that tick is not counted.
- R10: Clearing `fast_en` during an active interval does not shorten it.
- R11: The largest count, 8191, gives an interval of exactly 8191 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pfd_tick | input | 1 | One-cycle pulse per phase-detector period |
| fast_en | input | 1 | Fast-lock enable bit |
| fast_count | input | 13 | Interval length in phase-detector periods (1..8191) |
| freq_chg | input | 1 | One-cycle pulse on a frequency change |
| pll_run | input | 1 | PLL power-down pin level; 1 means running |
| switch_on | output | 1 | Loop-filter bypass switch closed |
| cp2_sel | output | 1 | High-current charge pump selected |
| cp1_sel | output | 1 | Normal charge pump selected |
| busy | output | 1 | Fast-lock interval in progress |

## Verification
The main function is exercised with both trigger kinds across several counts (1, 3, 5, 12) with the enable set. Each run checks that the interval ends on exactly the N-th tick and not one tick earlier. The same triggers are repeated with the enable cleared and with a zero count, which separates the gating of a start from the counting itself.

Directed cases then cover a retrigger mid-interval, a trigger coinciding with a tick, and a power-down mid-interval. They also cover a held-high run pin, an enable dropped mid-interval and the 8191 maximum. Together these distinguish reload from extension, priority between start and tick, and level from edge sensitivity.

// File: rtl/fl_pkg.sv
package fl_pkg;
  localparam int FL_CNT_W = 13;

  typedef enum logic [1:0] {
    FL_OP_HOLD,
    FL_OP_LOAD,
    FL_OP_DEC,
    FL_OP_CLR
  } fl_op_e;

  // Clear beats load, load beats a tick, and a tick only counts while active.
  function automatic fl_op_e fl_pick_op(input logic clr, input logic load,
                                        input logic tick, input logic active);
    if (clr)                 return FL_OP_CLR;
    else if (load)           return FL_OP_LOAD;
    else if (tick && active) return FL_OP_DEC;
    else                     return FL_OP_HOLD;
  endfunction

  function automatic logic fl_start_ok(input logic run, input logic en,
                                       input logic cause, input logic cnt_nz);
    return run && en && cause && cnt_nz;
  endfunction
endpackage

// File: rtl/fl_run_edge.sv
module fl_run_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic run_in,
  output logic run_rise
);
  logic run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_in;
  end

  assign run_rise = run_in && !run_q;
endmodule

// File: rtl/fl_interval_cnt.sv
module fl_interval_cnt
  import fl_pkg::*;
#(
  parameter int CNT_W = FL_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             active,
  output logic             expire_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] remain_q;
  fl_op_e           op;

  assign active     = (remain_q != '0);
  assign op         = fl_pick_op(clr, load, tick, active);
  assign expire_evt = (op == FL_OP_DEC) && (remain_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else begin
      case (op)
        FL_OP_CLR:  remain_q <= '0;
        FL_OP_LOAD: remain_q <= load_val;
        FL_OP_DEC:  remain_q <= remain_q - ONE;
        default:    remain_q <= remain_q;
      endcase
    end
  end
endmodule

// File: rtl/fl_pump_sel.sv
module fl_pump_sel (
  input  logic active,
  output logic switch_on,
  output logic cp2_sel,
  output logic cp1_sel
);
  assign switch_on = active;
  assign cp2_sel   = active;
  assign cp1_sel   = !active;
endmodule

// File: rtl/fastlock_timer.sv
module fastlock_timer
  import fl_pkg::*;
#(
  parameter int CNT_W = FL_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pfd_tick,
  input  logic             fast_en,
  input  logic [CNT_W-1:0] fast_count,
  input  logic             freq_chg,
  input  logic             pll_run,
  output logic             switch_on,
  output logic             cp2_sel,
  output logic             cp1_sel,
  output logic             busy
);
  logic run_rise;
  logic start_evt;
  logic expire_evt;
  logic clr_evt;

  fl_run_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_in   (pll_run),
    .run_rise (run_rise)
  );

  assign start_evt = fl_start_ok(pll_run, fast_en, freq_chg || run_rise,
                                 fast_count != '0);
  assign clr_evt   = !pll_run;

  fl_interval_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr_evt),
    .load       (start_evt),
    .load_val   (fast_count),
    .tick       (pfd_tick),
    .active     (busy),
    .expire_evt (expire_evt)
  );

  fl_pump_sel u_sel (
    .active    (busy),
    .switch_on (switch_on),
    .cp2_sel   (cp2_sel),
    .cp1_sel   (cp1_sel)
  );
endmodule

// File: rtl/fastlock_timer_chk.sv
module fastlock_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic pll_run,
  input logic fast_en,
  input logic pfd_tick,
  input logic start_evt,
  input logic expire_evt,
  input logic busy,
  input logic switch_on,
  input logic cp2_sel,
  input logic cp1_sel
);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

  // R8
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_run |=> !busy);

  // R5
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_en && !busy) |=> !busy);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pll_run && !pfd_tick) |=> busy);

  // R4
  expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && !start_evt) |=> !busy);

  // R1
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cp1_sel && !cp2_sel && !switch_on));

  // R2
  active_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!cp1_sel && cp2_sel && switch_on));
endmodule

bind fastlock_timer fastlock_timer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pll_run    (pll_run),
  .fast_en    (fast_en),
  .pfd_tick   (pfd_tick),
  .start_evt  (start_evt),
  .expire_evt (expire_evt),
  .busy       (busy),
  .switch_on  (switch_on),
  .cp2_sel    (cp2_sel),
  .cp1_sel    (cp1_sel)
);

// File: tb/fastlock_timer_tb.sv
module fastlock_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pfd_tick = 1'b0;
  logic        fast_en = 1'b0;
  logic [12:0] fast_count = '0;
  logic        freq_chg = 1'b0;
  logic        pll_run = 1'b0;
  logic        switch_on, cp2_sel, cp1_sel, busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fastlock_timer u_dut (
    .clk(clk), .rst_n(rst_n), .pfd_tick(pfd_tick), .fast_en(fast_en),
    .fast_count(fast_count), .freq_chg(freq_chg), .pll_run(pll_run),
    .switch_on(switch_on), .cp2_sel(cp2_sel), .cp1_sel(cp1_sel), .busy(busy)
  );

  // {enable, kind (0 = frequency change, 1 = run rise), expect start, count}
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b1, 13'd5},
    {1'b1, 1'b1, 1'b1, 13'd3},
    {1'b0, 1'b0, 1'b0, 13'd4},
    {1'b0, 1'b1, 1'b0, 13'd4},
    {1'b1, 1'b0, 1'b0, 13'd0},
    {1'b1, 1'b1, 1'b1, 13'd1},
    {1'b1, 1'b0, 1'b1, 13'd1},
    {1'b1, 1'b0, 1'b1, 13'd12}
  };

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Idle pattern is {busy,switch,cp2,cp1} = 0001; active is 1110.
  task automatic chk_out(input string tag, input logic act_exp);
    chk({tag, " busy"},   busy,      act_exp);
    chk({tag, " switch"}, switch_on, act_exp);
    chk({tag, " cp2"},    cp2_sel,   act_exp);
    chk({tag, " cp1"},    cp1_sel,   !act_exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      pfd_tick = 1'b1; cyc(); pfd_tick = 1'b0;
    end
  endtask

  task automatic fire_freq();
    freq_chg = 1'b1; cyc(); freq_chg = 1'b0;
  endtask

  task automatic fire_run();
    pll_run = 1'b0; cyc(); pll_run = 1'b1; cyc();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(); cyc();
    chk_out("R1 reset", 1'b0);
    rst_n = 1'b1;
    cyc();
    pll_run = 1'b1;
    cyc();  // first rise happens with fast_en = 0 and is ignored
    chk_out("R1 idle after release", 1'b0);

    for (int v = 0; v < NV; v++) begin
      logic        en, kind, exp_start;
      logic [12:0] n;
      {en, kind, exp_start, n} = VEC[v];
      fast_en = en; fast_count = n;
      if (kind) fire_run(); else fire_freq();
      if (!exp_start) begin
        chk_out(en ? "R6 zero count ignored" : "R5 disabled trigger ignored", 1'b0);
      end else begin
        chk_out(kind ? "R3 run rise start" : "R2 freq change start", 1'b1);
        if (n > 1) begin
          ticks(int'(n) - 1);
          chk("R4 active before last tick", busy, 1'b1);
        end
        ticks(1);
        chk_out("R4 idle after last tick", 1'b0);
      end
      cyc();
    end

    // R3: run held high does not retrigger
    fast_en = 1'b1; fast_count = 13'd2;
    repeat (4) cyc();
    chk("R3 held run no retrigger", busy, 1'b0);

    // R4: idle ticks do nothing; gaps between ticks do not shorten
    ticks(3);
    chk("R4 idle ticks", busy, 1'b0);
    fast_count = 13'd3;
    fire_freq();
    ticks(1); repeat (5) cyc(); ticks(1); repeat (3) cyc();
    chk("R4 gap keeps active", busy, 1'b1);
    ticks(1);
    chk("R4 ends on third tick", busy, 1'b0);

    // R7: retrigger reloads
    fast_count = 13'd6;
    fire_freq();
    ticks(3);
    fast_count = 13'd4;
    fire_freq();
    ticks(3);
    chk("R7 reload still active", busy, 1'b1);
    ticks(1);
    chk("R7 reload ends after new count", busy, 1'b0);

    // R9: start and tick together, tick not counted
    fast_count = 13'd2;
    freq_chg = 1'b1; pfd_tick = 1'b1; cyc(); freq_chg = 1'b0; pfd_tick = 1'b0;
    ticks(1);
    chk("R9 coincident tick not counted", busy, 1'b1);
    ticks(1);
    chk("R9 ends after two more ticks", busy, 1'b0);

    // R8: run low aborts and blocks triggers
    fast_count = 13'd9;
    fire_freq();
    ticks(2);
    pll_run = 1'b0; cyc();
    chk_out("R8 run low clears", 1'b0);
    freq_chg = 1'b1; cyc(); freq_chg = 1'b0;
    chk("R8 trigger while run low ignored", busy, 1'b0);
    pll_run = 1'b1; cyc();
    chk("R3 rise after power-down starts", busy, 1'b1);
    ticks(9);
    chk("R4 nine ticks end", busy, 1'b0);

    // R10: dropping enable mid-interval keeps running
    fast_count = 13'd4;
    fire_freq();
    fast_en = 1'b0;
    ticks(3);
    chk("R10 enable drop keeps interval", busy, 1'b1);
    ticks(1);
    chk("R10 ends on count", busy, 1'b0);
    fast_en = 1'b1;

    // R11: maximum count
    fast_count = 13'd8191;
    fire_freq();
    ticks(8190);
    chk("R11 max count active at 8190", busy, 1'b1);
    ticks(1);
    chk_out("R11 max count ends at 8191", 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule